// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block takes an incoming byte stream, marked with start-of-frame and end-of-frame flags, and scatters it into memory buffers described by a ring of descriptors. The descriptors sit in a small storage array inside the block. Each descriptor is two 32-bit words:

- The first word carries the buffer base address, a wrap flag and an ownership flag.
- The second word carries the filled length and the frame position flags.

Before the block starts a buffer it checks the ownership flag. When it finishes a buffer it writes back the length and position flags and marks the descriptor as used, which hands it over to software. Software then reads the descriptor, consumes the buffer and clears the used flag to give it back.

Buffer bytes leave on a single-byte write port as address/data pairs. Software reaches the descriptor array through a word-wide port: combinational read, synchronous write. A ring-base input selects which descriptor is first in the ring. A dropped-frame counter records frames that found no free descriptor.

Top module: `rxring_writer`

## Requirements
- R1: After reset every descriptor word reads 0, the drop counter is 0, no buffer write is issued and the ring pointer is descriptor 0.
- R2: A byte is accepted when `rx_valid` and `rx_en` are high and `base_we` is low. An accepted byte that is stored appears on `buf_we`/`buf_addr`/`buf_data` exactly one clock later. The address is `{word0[31:2],2'b00}` of the current descriptor plus the byte's offset within that buffer.
- R3: Closing a buffer has two effects. Word 1 becomes {16'b0, EOF at bit 15, SOF at bit 14, byte count in bits 13:0}. In word 0, bit 0 (used) becomes 1 while bits 31:1 are kept.
- R4: A buffer closes on the frame's last byte or when it holds BUF_BYTES bytes (default 1536). The frame then continues in the next descriptor. Only the first buffer of a frame carries SOF and only the last carries EOF; buffers in between carry neither.
- R5: After a descriptor whose word-0 bit 1 (wrap) is set, the next descriptor is the ring base. Otherwise the next descriptor is the following index, modulo NDESC.
- R6: If the descriptor needed for a new buffer has its used bit set, the block drops the rest of the frame. Dropping issues no buffer write, adds 1 to `drop_count` and leaves the ring pointer where it was.
- R7: Software writing word 0 with bit 0 cleared returns that descriptor; the next frame is stored into it.
- R8: While `rx_en` is low, input bytes produce no buffer write and leave the fill state unchanged.
- R9: A pulse on `base_we` loads `base_idx` as the ring base and moves the ring pointer there. Any partly filled buffer is abandoned without write-back, and a byte presented in that same cycle is ignored.
- R10: When software writes a descriptor in the same cycle as the block closes that same descriptor, the close wins and the software write is discarded. A software write to any other descriptor in that cycle takes effect.
- R11: While no frame is in progress, bytes without the start flag are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable |
| rx_valid | input | 1 | Byte present on rx_data |
| rx_data | input | 8 | Received byte |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_eof | input | 1 | Byte is the last of a frame |
| base_we | input | 1 | Load ring base and reset pointer |
| base_idx | input | IW | New ring base descriptor index |
| sw_idx | input | IW | Software descriptor index |
| sw_sel | input | 1 | Word select: 0 = address word, 1 = status word |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Selected descriptor word |
| buf_we | output | 1 | Buffer byte write strobe |
| buf_addr | output | 32 | Buffer byte address |
| buf_data | output | 8 | Buffer byte data |
| drop_count | output | DROP_W | Frames dropped for lack of a free descriptor |

## Verification
The block writes a descriptor back on its own while software may also be writing the descriptor array, so both can update storage in the same cycle. The bench provokes this by sending a one-byte frame while pulsing `sw_we` in the same clock. It does this twice: once aimed at the descriptor being closed, and once aimed at another descriptor. It then reads both words back. It judges that the closed descriptor shows the block's length, flags and used bit with the software value discarded, and that the other descriptor holds exactly the software value.

// File: rtl/rxring_pkg.sv
package rxring_pkg;
  localparam int USED_POS = 0;
  localparam int WRAP_POS = 1;
  localparam int LEN_W    = 14;
  localparam int SOF_POS  = 14;
  localparam int EOF_POS  = 15;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_FILL = 2'd1,
    FS_DROP = 2'd2
  } fill_state_e;
endpackage

// File: rtl/rxring_desc_mem.sv
module rxring_desc_mem #(
  parameter int NDESC = 4,
  parameter int IW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] sw_idx,
  input  logic          sw_sel,
  input  logic          sw_we,
  input  logic [31:0]   sw_wdata,
  output logic [31:0]   sw_rdata,
  input  logic [IW-1:0] chk_idx,
  output logic [31:0]   chk_w0,
  input  logic          cl_we,
  input  logic [IW-1:0] cl_idx,
  input  logic [31:0]   cl_w1
);
  import rxring_pkg::*;

  logic [31:0] w0_q [NDESC];
  logic [31:0] w1_q [NDESC];
  logic [31:0] w0_n [NDESC];
  logic [31:0] w1_n [NDESC];

  always_comb begin
    for (int i = 0; i < NDESC; i++) begin
      w0_n[i] = w0_q[i];
      w1_n[i] = w1_q[i];
      if (cl_we && cl_idx == IW'(i)) begin
        w0_n[i][USED_POS] = 1'b1;
        w1_n[i]           = cl_w1;
      end else if (sw_we && sw_idx == IW'(i)) begin
        if (sw_sel) w1_n[i] = sw_wdata;
        else        w0_n[i] = sw_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NDESC; i++) begin
        w0_q[i] <= '0;
        w1_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NDESC; i++) begin
        w0_q[i] <= w0_n[i];
        w1_q[i] <= w1_n[i];
      end
    end
  end

  assign sw_rdata = sw_sel ? w1_q[sw_idx] : w0_q[sw_idx];
  assign chk_w0   = w0_q[chk_idx];

  for (genvar g = 0; g < NDESC; g++) begin : g_chk
    // R3: a closed descriptor is owned by software on the next cycle
    a_r3_used_after_close: assert property (@(posedge clk) disable iff (!rst_n)
      (cl_we && cl_idx == IW'(g)) |=> w0_q[g][USED_POS]);
    // R10: on a same-cycle collision the status word takes the block's value
    a_r10_close_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (cl_we && cl_idx == IW'(g) && sw_we && sw_idx == IW'(g))
      |=> w1_q[g] == $past(cl_w1));
  end
endmodule

// File: rtl/rxring_ptr.sv
module rxring_ptr #(
  parameter int NDESC = 4,
  parameter int IW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          base_we,
  input  logic [IW-1:0] base_idx,
  input  logic          adv,
  input  logic          wrap,
  output logic [IW-1:0] ptr
);
  localparam logic [IW-1:0] LAST = IW'(NDESC - 1);

  logic [IW-1:0] base_q, base_n, ptr_q, ptr_n;

  always_comb begin
    base_n = base_q;
    ptr_n  = ptr_q;
    if (base_we) begin
      base_n = base_idx;
      ptr_n  = base_idx;
    end else if (adv) begin
      if (wrap)               ptr_n = base_q;
      else if (ptr_q == LAST) ptr_n = '0;
      else                    ptr_n = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      ptr_q  <= '0;
    end else begin
      base_q <= base_n;
      ptr_q  <= ptr_n;
    end
  end

  assign ptr = ptr_q;

  a_r9_base_load: assert property (@(posedge clk) disable iff (!rst_n)
    base_we |=> ptr_q == $past(base_idx));
  a_r5_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= LAST);
  a_r6_hold_without_adv: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !base_we) |=> $stable(ptr_q));
endmodule

// File: rtl/rxring_fill.sv
module rxring_fill #(
  parameter int BUF_BYTES = 1536,
  parameter int DROP_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic              abort,
  input  logic [31:0]       cur_w0,
  output logic              adv,
  output logic              cl_we,
  output logic [31:0]       cl_w1,
  output logic              buf_we,
  output logic [31:0]       buf_addr,
  output logic [7:0]        buf_data,
  output logic [DROP_W-1:0] drop_count
);
  import rxring_pkg::*;

  localparam int LW = $clog2(BUF_BYTES + 1);
  localparam logic [LW-1:0] FULL = LW'(BUF_BYTES);

  fill_state_e       st_q, st_n;
  logic [LW-1:0]     cnt_q, cnt_n, offset, new_len;
  logic              first_q, first_n;
  logic [DROP_W-1:0] drop_q, drop_n;
  logic              take, used, need_desc, wr, drop_inc, sof_flag;
  logic              we_q;
  logic [31:0]       addr_q, addr_n;
  logic [7:0]        data_q;

  always_comb begin
    take      = rx_valid && rx_en && !abort;
    used      = cur_w0[USED_POS];
    need_desc = take && ((st_q == FS_IDLE && rx_sof) ||
                         (st_q == FS_FILL && cnt_q == '0));
    drop_inc  = need_desc && used;
    wr        = take && !drop_inc &&
                ((st_q == FS_IDLE && rx_sof) || st_q == FS_FILL);
    offset    = (st_q == FS_IDLE) ? '0 : cnt_q;
    new_len   = offset + 1'b1;
    sof_flag  = (st_q == FS_IDLE) ? 1'b1 : first_q;
    cl_we     = wr && (rx_eof || new_len == FULL);
    cl_w1     = '0;
    cl_w1[LEN_W-1:0] = LEN_W'(new_len);
    cl_w1[SOF_POS]   = sof_flag;
    cl_w1[EOF_POS]   = rx_eof;
    adv       = cl_we;
    addr_n    = {cur_w0[31:2], 2'b00} + 32'(offset);

    st_n    = st_q;
    cnt_n   = cnt_q;
    first_n = first_q;
    drop_n  = drop_inc ? drop_q + 1'b1 : drop_q;
    if (abort) begin
      st_n  = FS_IDLE;
      cnt_n = '0;
    end else if (drop_inc) begin
      st_n  = rx_eof ? FS_IDLE : FS_DROP;
      cnt_n = '0;
    end else if (wr) begin
      if (cl_we) begin
        st_n    = rx_eof ? FS_IDLE : FS_FILL;
        cnt_n   = '0;
        first_n = 1'b0;
      end else begin
        st_n    = FS_FILL;
        cnt_n   = new_len;
        first_n = sof_flag;
      end
    end else if (st_q == FS_DROP && take && rx_eof) begin
      st_n = FS_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= FS_IDLE;
      cnt_q   <= '0;
      first_q <= 1'b0;
      drop_q  <= '0;
      we_q    <= 1'b0;
    end else begin
      st_q    <= st_n;
      cnt_q   <= cnt_n;
      first_q <= first_n;
      drop_q  <= drop_n;
      we_q    <= wr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (wr) begin
      addr_q <= addr_n;
      data_q <= rx_data;
    end
  end

  assign buf_we     = we_q;
  assign buf_addr   = addr_q;
  assign buf_data   = data_q;
  assign drop_count = drop_q;

  a_r2_write_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> $past(take));
  a_r6_drop_counts: assert property (@(posedge clk) disable iff (!rst_n)
    drop_inc |=> drop_q == $past(drop_q) + 1'b1);
  a_r4_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cl_we |-> (cl_w1[LEN_W-1:0] != '0 && cl_w1[LEN_W-1:0] <= LEN_W'(BUF_BYTES)));
  a_r8_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !buf_we);
  a_r9_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> st_q == FS_IDLE);
endmodule

// File: rtl/rxring_writer.sv
module rxring_writer #(
  parameter int NDESC     = 4,
  parameter int BUF_BYTES = 1536,
  parameter int DROP_W    = 16,
  localparam int IW       = (NDESC > 1) ? $clog2(NDESC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic              base_we,
  input  logic [IW-1:0]     base_idx,
  input  logic [IW-1:0]     sw_idx,
  input  logic              sw_sel,
  input  logic              sw_we,
  input  logic [31:0]       sw_wdata,
  output logic [31:0]       sw_rdata,
  output logic              buf_we,
  output logic [31:0]       buf_addr,
  output logic [7:0]        buf_data,
  output logic [DROP_W-1:0] drop_count
);
  import rxring_pkg::*;

  logic [IW-1:0] ptr;
  logic [31:0]   cur_w0, cl_w1;
  logic          cl_we, adv;

  rxring_desc_mem #(.NDESC(NDESC), .IW(IW)) mem_i (
    .clk(clk), .rst_n(rst_n),
    .sw_idx(sw_idx), .sw_sel(sw_sel), .sw_we(sw_we), .sw_wdata(sw_wdata),
    .sw_rdata(sw_rdata),
    .chk_idx(ptr), .chk_w0(cur_w0),
    .cl_we(cl_we), .cl_idx(ptr), .cl_w1(cl_w1)
  );

  rxring_ptr #(.NDESC(NDESC), .IW(IW)) ptr_i (
    .clk(clk), .rst_n(rst_n),
    .base_we(base_we), .base_idx(base_idx),
    .adv(adv), .wrap(cur_w0[WRAP_POS]), .ptr(ptr)
  );

  rxring_fill #(.BUF_BYTES(BUF_BYTES), .DROP_W(DROP_W)) fill_i (
    .clk(clk), .rst_n(rst_n),
    .rx_en(rx_en), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_sof(rx_sof), .rx_eof(rx_eof), .abort(base_we),
    .cur_w0(cur_w0), .adv(adv), .cl_we(cl_we), .cl_w1(cl_w1),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_data(buf_data),
    .drop_count(drop_count)
  );

  // R6: a descriptor is only filled while software has released it
  a_r6_fill_only_free: assert property (@(posedge clk) disable iff (!rst_n)
    cl_we |-> !cur_w0[USED_POS]);
endmodule

// File: tb/rxring_writer_tb_top.sv
module rxring_writer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NDESC = 4;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_en = 1'b0, rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
  logic [7:0] rx_data = '0;
  logic base_we = 1'b0;
  logic [IW-1:0] base_idx = '0;
  logic [IW-1:0] sw_idx = '0;
  logic sw_sel = 1'b0, sw_we = 1'b0;
  logic [31:0] sw_wdata = '0;
  logic [31:0] sw_rdata, buf_addr;
  logic buf_we;
  logic [7:0] buf_data;
  logic [15:0] drop_count;

  int checks = 0, errors = 0;
  int log_n = 0;
  logic [31:0] log_a [4096];
  logic [7:0]  log_d [4096];

  always #(CLK_PERIOD/2) clk = ~clk;

  rxring_writer #(.NDESC(NDESC), .BUF_BYTES(1536), .DROP_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .base_we(base_we), .base_idx(base_idx),
    .sw_idx(sw_idx), .sw_sel(sw_sel), .sw_we(sw_we), .sw_wdata(sw_wdata),
    .sw_rdata(sw_rdata), .buf_we(buf_we), .buf_addr(buf_addr),
    .buf_data(buf_data), .drop_count(drop_count)
  );

  always @(negedge clk) begin
    if (buf_we) begin
      if (log_n < 4096) begin
        log_a[log_n] = buf_addr;
        log_d[log_n] = buf_data;
      end
      log_n = log_n + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic sw_write(input int idx, input bit sel, input logic [31:0] v);
    @(negedge clk);
    sw_idx = IW'(idx); sw_sel = sel; sw_wdata = v; sw_we = 1'b1;
    @(negedge clk);
    sw_we = 1'b0;
  endtask

  task automatic sw_read(input int idx, input bit sel, output logic [31:0] v);
    @(negedge clk);
    sw_idx = IW'(idx); sw_sel = sel;
    #1 v = sw_rdata;
  endtask

  task automatic set_base(input int idx);
    @(negedge clk);
    base_idx = IW'(idx); base_we = 1'b1;
    @(negedge clk);
    base_we = 1'b0;
  endtask

  function automatic logic [31:0] w0_init(input int i);
    return (32'(i + 1) << 12) | ((i == NDESC - 1) ? 32'h2 : 32'h0);
  endfunction

  task automatic ring_init(input int base);
    for (int i = 0; i < NDESC; i++) begin
      sw_write(i, 1'b0, w0_init(i));
      sw_write(i, 1'b1, 32'h0);
    end
    set_base(base);
    log_n = 0;
  endtask

  task automatic put_byte(input logic [7:0] d, input bit s, input bit e);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d; rx_sof = s; rx_eof = e;
  endtask

  task automatic idle_rx();
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic send_frame(input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++)
      put_byte(seed + 8'(i), i == 0, i == n - 1);
    idle_rx();
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check(buf_we == 1'b0, "R1 buf_we", 32'(buf_we), 0);
    check(drop_count == 0, "R1 drop", 32'(drop_count), 0);
    sw_read(0, 1'b0, v); check(v == 0, "R1 word0", v, 0);
    sw_read(NDESC - 1, 1'b1, v); check(v == 0, "R1 word1", v, 0);
    // R1: pointer at descriptor 0; first frame lands at desc0 address
    sw_write(0, 1'b0, 32'h0000_1000);
    log_n = 0;
    send_frame(1, 8'h3C);
    check(log_n == 1 && log_a[0] == 32'h1000, "R1 pointer", log_a[0], 32'h1000);
  endtask

  task automatic t_single();
    logic [31:0] v;
    ring_init(0);
    send_frame(5, 8'h10);
    check(log_n == 5, "R2 count", 32'(log_n), 5);
    check(log_a[4] == 32'h1004 && log_d[4] == 8'h14, "R2 addr/data",
          log_a[4], 32'h1004);
    sw_read(0, 1'b1, v); check(v == 32'hC005, "R3 word1", v, 32'hC005);
    sw_read(0, 1'b0, v); check(v == 32'h1001, "R3 word0 used", v, 32'h1001);
  endtask

  task automatic t_idle_nosof();
    ring_init(0);
    for (int i = 0; i < 3; i++) put_byte(8'hA0, 1'b0, i == 2);
    idle_rx();
    check(log_n == 0, "R11 ignored", 32'(log_n), 0);
    send_frame(1, 8'h55);
    check(log_a[0] == 32'h1000, "R11 next frame desc0", log_a[0], 32'h1000);
  endtask

  task automatic t_disabled();
    logic [31:0] v;
    ring_init(0);
    rx_en = 1'b0;
    send_frame(4, 8'h20);
    check(log_n == 0, "R8 no write", 32'(log_n), 0);
    sw_read(0, 1'b0, v); check(v == 32'h1000, "R8 desc untouched", v, 32'h1000);
    rx_en = 1'b1;
    send_frame(1, 8'h21);
    check(log_n == 1 && log_a[0] == 32'h1000, "R8 state kept", log_a[0], 32'h1000);
  endtask

  task automatic t_multi_wrap_drop();
    logic [31:0] v;
    int bad;
    ring_init(0);
    send_frame(3100, 8'h00);
    check(log_n == 3100, "R4 byte count", 32'(log_n), 3100);
    bad = 0;
    for (int j = 0; j < 3100 && j < log_n; j++)
      if (log_a[j] != (32'((j / 1536) + 1) << 12) + 32'(j % 1536) ||
          log_d[j] != 8'(j)) bad++;
    check(bad == 0, "R4 addresses across buffers", 32'(bad), 0);
    sw_read(0, 1'b1, v); check(v == 32'h4600, "R4 first SOF only", v, 32'h4600);
    sw_read(1, 1'b1, v); check(v == 32'h0600, "R4 middle no flags", v, 32'h0600);
    sw_read(2, 1'b1, v); check(v == 32'h801C, "R4 last EOF only", v, 32'h801C);
    send_frame(1, 8'h77);
    sw_read(3, 1'b0, v); check(v == 32'h4003, "R5 wrap desc used", v, 32'h4003);
    log_n = 0;
    send_frame(6, 8'h88);
    check(log_n == 0, "R6 drop no write", 32'(log_n), 0);
    check(drop_count == 1, "R6 drop counter", 32'(drop_count), 1);
    sw_write(0, 1'b0, 32'h1000);
    send_frame(2, 8'h99);
    check(log_n == 2 && log_a[0] == 32'h1000, "R5 R7 after wrap returns desc0",
          log_a[0], 32'h1000);
    sw_read(0, 1'b1, v); check(v == 32'hC002, "R7 reused word1", v, 32'hC002);
  endtask

  task automatic t_base();
    logic [31:0] v;
    ring_init(2);
    for (int i = 0; i < 3; i++) put_byte(8'h40 + 8'(i), i == 0, 1'b0);
    idle_rx();
    check(log_n == 3 && log_a[0] == 32'h3000, "R9 base pointer", log_a[0], 32'h3000);
    set_base(1);
    sw_read(2, 1'b0, v); check(v == 32'h3000, "R9 abandoned not used", v, 32'h3000);
    log_n = 0;
    send_frame(1, 8'h50);
    check(log_n == 1 && log_a[0] == 32'h2000, "R9 new base", log_a[0], 32'h2000);
    sw_read(1, 1'b0, v); check(v == 32'h2001, "R9 desc1 used", v, 32'h2001);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    ring_init(2);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = 8'hE1; rx_sof = 1'b1; rx_eof = 1'b1;
    sw_idx = 2'd2; sw_sel = 1'b0; sw_wdata = 32'h7770; sw_we = 1'b1;
    @(negedge clk);
    sw_we = 1'b0;
    idle_rx();
    sw_read(2, 1'b0, v); check(v == 32'h3001, "R10 same desc close wins", v, 32'h3001);
    sw_read(2, 1'b1, v); check(v == 32'hC001, "R10 same desc word1", v, 32'hC001);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = 8'hE2; rx_sof = 1'b1; rx_eof = 1'b1;
    sw_idx = 2'd0; sw_sel = 1'b0; sw_wdata = 32'h5550; sw_we = 1'b1;
    @(negedge clk);
    sw_we = 1'b0;
    idle_rx();
    sw_read(0, 1'b0, v); check(v == 32'h5550, "R10 other desc written", v, 32'h5550);
    sw_read(3, 1'b0, v); check(v == 32'h4003, "R10 closed desc3", v, 32'h4003);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=0x%08h expected=0x%08h", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rx_en = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_idle_nosof();
    t_disabled();
    t_multi_wrap_drop();
    t_base();
    t_collide();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule